// File: doc/BRIEF.md
# Lane Rate and Power-State Change Sequencer

This block owns the per-lane control fields that set the power state, the lane rate and the sample rate of a group of serial lanes. There are two power-state fields, one for receive and one for transmit, two rate fields, and a transmit sample-rate field. While the global reset is applied, and for as long as the init-done input is low, each field sits at its required start-up value. Requests are refused in that period. Once initialization is complete, a host asks for one change at a time. A change names one target field, a lane mask and a code. The sequencer checks the request, drives the new encoding on the addressed lanes and then waits until every addressed lane has returned its completion acknowledgment.

Acknowledgments are pulses on a receive bus and on a transmit bus, one bit per lane. The sequencer trusts them only while init-done is high and the user clock is reported stable. In the bonded four-lane mode only lane 0 is written and only lane 0 is awaited. A change that does not complete within a programmable number of cycles ends with a timeout flag. The sequencer then returns to idle, and the new value stays on the field.

Top module: `lane_ctl_seq`

## Requirements
- R1: Both power-state fields (2 bits per lane) use code 00 for normal operation and code 10 for off. A request for a power state with any other code is treated as reserved.
- R2: While rst_n is low or init_done is low, every receive and transmit power field reads 10, every rate field reads 00 and every sample-rate field reads 000, all one cycle after init_done is seen low. Any request in that state gives a one-cycle req_refused pulse.
- R3: Legal request codes are 000 and 010. In a 2-bit field the code 010 is driven as 10: 00 means full rate and 10 means quarter rate. In the 3-bit sample-rate field 000 means full and 010 means quarter. A target value of 5, 6 or 7, or any other code, produces a one-cycle err_code pulse on the next cycle, and no field changes.
- R4: The target encoding is 0 for receive power, 1 for receive rate, 2 for transmit power, 3 for transmit rate and 4 for sample rate. An accepted request writes the code into the target field of every lane whose bit is set in req_lanes (lane i at bits [i*W +: W]). It also raises busy, and both changes are visible on the cycle after the request. A request with an empty lane mask is refused.
- R5: busy stays high until every addressed lane has pulsed its acknowledgment on the matching bus. Targets 0 and 1 use rx_ack, and the others use tx_ack. On the cycle after the last of those acknowledgments, done pulses for one cycle and busy drops.
- R6: An acknowledgment is ignored while clk_stable is low. An acknowledgment on the bus that does not belong to the pending change is also ignored.
- R7: With bonded high, any request that has a non-empty mask writes and awaits lane 0 only. The fields of lanes 1 to 3 do not change.
- R8: A receive-rate request is refused unless every addressed lane's transmit power field reads 00.
- R9: While busy is high, a request gives a req_refused pulse and changes no field.
- R10: If a change has not completed by the tmo_limit-th cycle after its request, err_tmo pulses for one cycle and busy drops, while the new field values remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Global reset, active low |
| init_done | input | 1 | Initialization complete |
| clk_stable | input | 1 | User clock is stable; gates acknowledgments |
| bonded | input | 1 | Bonded four-lane mode, lane 0 only |
| tmo_limit | input | TW | Cycles allowed for a change |
| req_valid | input | 1 | Change request strobe |
| req_tgt | input | 3 | Target field select |
| req_lanes | input | NL | Lane mask |
| req_code | input | 3 | Requested encoding |
| rx_ack | input | NL | Receive-side completion pulses |
| tx_ack | input | NL | Transmit-side completion pulses |
| rx_pwr | output | 2*NL | Receive power-state fields |
| rx_rate | output | 2*NL | Receive rate fields |
| tx_pwr | output | 2*NL | Transmit power-state fields |
| tx_rate | output | 2*NL | Transmit rate fields |
| tx_srate | output | 3*NL | Transmit sample-rate fields |
| busy | output | 1 | A change is waiting for acknowledgment |
| done | output | 1 | One-cycle pulse when a change completes |
| err_tmo | output | 1 | One-cycle timeout pulse |
| err_code | output | 1 | One-cycle reserved-code pulse |
| req_refused | output | 1 | One-cycle pulse for a request that was refused |

## Verification
The bench builds the block with NL = 4 and TW = 8 and drives tmo_limit at 5. With four lanes, acknowledgments can arrive over several cycles and the bonded mode has lanes to leave alone. With a short limit, a timeout is reached within a few idle cycles. A reference model restates the accept rules, the pending-lane bookkeeping and the timeout count. It predicts every field, busy and each status pulse cycle by cycle.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam logic [2:0] TGT_RX_PWR   = 3'd0;
  localparam logic [2:0] TGT_RX_RATE  = 3'd1;
  localparam logic [2:0] TGT_TX_PWR   = 3'd2;
  localparam logic [2:0] TGT_TX_RATE  = 3'd3;
  localparam logic [2:0] TGT_TX_SRATE = 3'd4;

  localparam logic [1:0] PWR_ON    = 2'b00;
  localparam logic [1:0] PWR_OFF   = 2'b10;
  localparam logic [1:0] RATE_FULL = 2'b00;
  localparam logic [1:0] RATE_QTR  = 2'b10;
  localparam logic [2:0] SR_FULL   = 3'b000;
  localparam logic [2:0] SR_QTR    = 3'b010;

  // Every field accepts only the full/on code or the quarter/off code.
  function automatic logic code_legal(input logic [2:0] tgt, input logic [2:0] code);
    logic ok;
    ok = 1'b0;
    case (tgt)
      TGT_RX_PWR, TGT_TX_PWR:   ok = (code[1:0] == PWR_ON || code[1:0] == PWR_OFF) && !code[2];
      TGT_RX_RATE, TGT_TX_RATE: ok = (code[1:0] == RATE_FULL || code[1:0] == RATE_QTR) && !code[2];
      TGT_TX_SRATE:             ok = (code == SR_FULL || code == SR_QTR);
      default:                  ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic tgt_on_tx(input logic [2:0] tgt);
    return (tgt == TGT_TX_PWR) || (tgt == TGT_TX_RATE) || (tgt == TGT_TX_SRATE);
  endfunction
endpackage

// File: rtl/lcs_field_bank.sv
module lcs_field_bank #(
  parameter int NL = 4,
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            we,
  input  logic [NL-1:0]   lane_sel,
  input  logic [W-1:0]    code,
  output logic [NL*W-1:0] q
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   val <= RST_VAL;
      else if (hold)                val <= RST_VAL;
      else if (we && lane_sel[i])   val <= code;
    end
    assign q[i*W +: W] = val;
  end
endmodule

// File: rtl/lcs_req_check.sv
module lcs_req_check
  import lcs_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic            init_done,
  input  logic            busy,
  input  logic            bonded,
  input  logic            req_valid,
  input  logic [2:0]      req_tgt,
  input  logic [NL-1:0]   req_lanes,
  input  logic [2:0]      req_code,
  input  logic [2*NL-1:0] tx_pwr,
  output logic [NL-1:0]   eff_lanes,
  output logic            accept,
  output logic            bad_code,
  output logic            refuse
);
  logic open_win;
  logic legal;
  logic tx_ready;
  logic lanes_ok;

  always_comb begin
    eff_lanes = req_lanes;
    if (bonded) begin
      eff_lanes    = '0;
      eff_lanes[0] = |req_lanes;
    end
  end

  always_comb begin
    tx_ready = 1'b1;
    for (int i = 0; i < NL; i++)
      if (eff_lanes[i] && tx_pwr[2*i +: 2] != PWR_ON) tx_ready = 1'b0;
  end

  assign open_win = init_done && !busy;
  assign legal    = code_legal(req_tgt, req_code);
  assign lanes_ok = (|eff_lanes) && ((req_tgt != TGT_RX_RATE) || tx_ready);
  assign accept   = req_valid && open_win && legal && lanes_ok;
  assign bad_code = req_valid && open_win && !legal;
  assign refuse   = req_valid && (!open_win || (legal && !lanes_ok));
endmodule

// File: rtl/lcs_ack_track.sv
module lcs_ack_track #(
  parameter int NL = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          start,
  input  logic [NL-1:0] start_lanes,
  input  logic          start_tx,
  input  logic          ack_ok,
  input  logic [NL-1:0] rx_ack,
  input  logic [NL-1:0] tx_ack,
  input  logic [TW-1:0] limit,
  output logic          busy,
  output logic          done_ev,
  output logic          tmo_ev
);
  logic [NL-1:0] pend, pend_nxt, ack_use;
  logic          side_tx;
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_inc;

  assign ack_use  = ack_ok ? (side_tx ? tx_ack : rx_ack) : '0;
  assign pend_nxt = pend & ~ack_use;
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign done_ev  = busy && !hold && (pend_nxt == '0);
  assign tmo_ev   = busy && !hold && !done_ev && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pend <= '0; side_tx <= 1'b0; cnt <= '0;
    end else if (hold) begin
      busy <= 1'b0; pend <= '0; cnt <= '0;
    end else if (start) begin
      busy <= 1'b1; pend <= start_lanes; side_tx <= start_tx; cnt <= '0;
    end else if (busy) begin
      pend <= pend_nxt;
      if (done_ev || tmo_ev) busy <= 1'b0;
      else                   cnt  <= cnt_inc[TW-1:0];
    end
  end
endmodule

// File: rtl/lane_ctl_seq.sv
module lane_ctl_seq
  import lcs_pkg::*;
#(
  parameter int NL = 4,
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_done,
  input  logic            clk_stable,
  input  logic            bonded,
  input  logic [TW-1:0]   tmo_limit,
  input  logic            req_valid,
  input  logic [2:0]      req_tgt,
  input  logic [NL-1:0]   req_lanes,
  input  logic [2:0]      req_code,
  input  logic [NL-1:0]   rx_ack,
  input  logic [NL-1:0]   tx_ack,
  output logic [2*NL-1:0] rx_pwr,
  output logic [2*NL-1:0] rx_rate,
  output logic [2*NL-1:0] tx_pwr,
  output logic [2*NL-1:0] tx_rate,
  output logic [3*NL-1:0] tx_srate,
  output logic            busy,
  output logic            done,
  output logic            err_tmo,
  output logic            err_code,
  output logic            req_refused
);
  logic          hold;
  logic [NL-1:0] eff_lanes;
  logic          acc_ev, bad_ev, ref_ev, done_ev, tmo_ev;
  logic          ack_ok;

  assign hold   = !init_done;
  assign ack_ok = init_done && clk_stable;

  lcs_req_check #(.NL(NL)) u_chk_req (
    .init_done(init_done), .busy(busy), .bonded(bonded),
    .req_valid(req_valid), .req_tgt(req_tgt), .req_lanes(req_lanes),
    .req_code(req_code), .tx_pwr(tx_pwr), .eff_lanes(eff_lanes),
    .accept(acc_ev), .bad_code(bad_ev), .refuse(ref_ev)
  );

  lcs_ack_track #(.NL(NL), .TW(TW)) u_track (
    .clk(clk), .rst_n(rst_n), .hold(hold), .start(acc_ev),
    .start_lanes(eff_lanes), .start_tx(tgt_on_tx(req_tgt)), .ack_ok(ack_ok),
    .rx_ack(rx_ack), .tx_ack(tx_ack), .limit(tmo_limit),
    .busy(busy), .done_ev(done_ev), .tmo_ev(tmo_ev)
  );

  lcs_field_bank #(.NL(NL), .W(2), .RST_VAL(PWR_OFF)) u_rx_pwr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(acc_ev && req_tgt == TGT_RX_PWR),
    .lane_sel(eff_lanes), .code(req_code[1:0]), .q(rx_pwr));
  lcs_field_bank #(.NL(NL), .W(2), .RST_VAL(RATE_FULL)) u_rx_rate (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(acc_ev && req_tgt == TGT_RX_RATE),
    .lane_sel(eff_lanes), .code(req_code[1:0]), .q(rx_rate));
  lcs_field_bank #(.NL(NL), .W(2), .RST_VAL(PWR_OFF)) u_tx_pwr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(acc_ev && req_tgt == TGT_TX_PWR),
    .lane_sel(eff_lanes), .code(req_code[1:0]), .q(tx_pwr));
  lcs_field_bank #(.NL(NL), .W(2), .RST_VAL(RATE_FULL)) u_tx_rate (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(acc_ev && req_tgt == TGT_TX_RATE),
    .lane_sel(eff_lanes), .code(req_code[1:0]), .q(tx_rate));
  lcs_field_bank #(.NL(NL), .W(3), .RST_VAL(SR_FULL)) u_tx_srate (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(acc_ev && req_tgt == TGT_TX_SRATE),
    .lane_sel(eff_lanes), .code(req_code), .q(tx_srate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; err_tmo <= 1'b0; err_code <= 1'b0; req_refused <= 1'b0;
    end else begin
      done        <= done_ev;
      err_tmo     <= tmo_ev;
      err_code    <= bad_ev;
      req_refused <= ref_ev;
    end
  end
endmodule

// File: rtl/lane_ctl_seq_chk.sv
module lane_ctl_seq_chk #(
  parameter int NL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_done,
  input logic            bonded,
  input logic            req_valid,
  input logic            acc_ev,
  input logic [2*NL-1:0] rx_pwr,
  input logic [2*NL-1:0] rx_rate,
  input logic [2*NL-1:0] tx_pwr,
  input logic [2*NL-1:0] tx_rate,
  input logic [3*NL-1:0] tx_srate,
  input logic            busy,
  input logic            done,
  input logic            err_tmo,
  input logic            err_code,
  input logic            req_refused
);
  logic [11*NL-1:0] all_f;
  logic [4*NL-5:0]  hi_pwr;
  logic [2*NL-1:0]  off_pat;
  logic             codes_ok;

  assign all_f  = {rx_pwr, rx_rate, tx_pwr, tx_rate, tx_srate};
  assign hi_pwr = {rx_pwr[2*NL-1:2], tx_pwr[2*NL-1:2]};

  always_comb begin
    codes_ok = 1'b1;
    off_pat  = '0;
    for (int i = 0; i < NL; i++) begin
      off_pat[2*i+1] = 1'b1;
      if (rx_rate[2*i +: 2] == 2'b01 || rx_rate[2*i +: 2] == 2'b11) codes_ok = 1'b0;
      if (tx_rate[2*i +: 2] == 2'b01 || tx_rate[2*i +: 2] == 2'b11) codes_ok = 1'b0;
      if (rx_pwr[2*i] || tx_pwr[2*i]) codes_ok = 1'b0;
      if (tx_srate[3*i +: 3] != 3'b000 && tx_srate[3*i +: 3] != 3'b010) codes_ok = 1'b0;
    end
  end

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> (rx_pwr == off_pat && tx_pwr == off_pat && rx_rate == '0 && tx_rate == '0 && tx_srate == '0)); // R2
  AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    codes_ok); // R3
  AST_CODE_ERR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    err_code |-> $stable(all_f)); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |=> busy); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_BONDED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bonded && init_done) |=> $stable(hi_pwr)); // R7
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> req_refused); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && init_done) |=> $stable(all_f)); // R9
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |-> (!busy && $past(busy))); // R10
endmodule

bind lane_ctl_seq lane_ctl_seq_chk #(.NL(NL)) u_sva (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .bonded(bonded),
  .req_valid(req_valid), .acc_ev(acc_ev), .rx_pwr(rx_pwr), .rx_rate(rx_rate),
  .tx_pwr(tx_pwr), .tx_rate(tx_rate), .tx_srate(tx_srate), .busy(busy),
  .done(done), .err_tmo(err_tmo), .err_code(err_code), .req_refused(req_refused)
);

// File: tb/sim_lane_ctl_seq.sv
module sim_lane_ctl_seq;
  localparam int NL = 4;
  localparam int TW = 8;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0, clk_stable = 1'b0, bonded = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_tgt = '0, req_code = '0;
  logic [NL-1:0] req_lanes = '0, rx_ack = '0, tx_ack = '0;
  logic [2*NL-1:0] rx_pwr, rx_rate, tx_pwr, tx_rate;
  logic [3*NL-1:0] tx_srate;
  logic busy, done, err_tmo, err_code, req_refused;

  lane_ctl_seq #(.NL(NL), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .clk_stable(clk_stable),
    .bonded(bonded), .tmo_limit(TW'(LIM)), .req_valid(req_valid), .req_tgt(req_tgt),
    .req_lanes(req_lanes), .req_code(req_code), .rx_ack(rx_ack), .tx_ack(tx_ack),
    .rx_pwr(rx_pwr), .rx_rate(rx_rate), .tx_pwr(tx_pwr), .tx_rate(tx_rate),
    .tx_srate(tx_srate), .busy(busy), .done(done), .err_tmo(err_tmo),
    .err_code(err_code), .req_refused(req_refused)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  // reference model state
  logic [1:0] m_rxp [NL], m_rxr [NL], m_txp [NL], m_txr [NL];
  logic [2:0] m_txs [NL];
  bit m_busy = 0, m_side = 0;
  logic [NL-1:0] m_pend = '0;
  int m_cnt = 0;
  string cur_tag = "R2";

  typedef struct { logic [3:0] p; string tag; } item_t;  // p = {done,tmo,code,refused}
  item_t q[$];

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin
      m_rxp[i] = 2'b10; m_txp[i] = 2'b10; m_rxr[i] = 2'b00; m_txr[i] = 2'b00; m_txs[i] = 3'b000;
    end
    m_busy = 0; m_pend = '0; m_cnt = 0;
  endtask

  function automatic logic [11*NL-1:0] model_flat();
    logic [2*NL-1:0] a, b, c, d;
    logic [3*NL-1:0] e;
    for (int i = 0; i < NL; i++) begin
      a[2*i +: 2] = m_rxp[i]; b[2*i +: 2] = m_rxr[i]; c[2*i +: 2] = m_txp[i];
      d[2*i +: 2] = m_txr[i]; e[3*i +: 3] = m_txs[i];
    end
    return {a, b, c, d, e};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model advanced to the next edge
  task automatic step(input bit rv, input logic [2:0] tg, input logic [3:0] m,
                      input logic [2:0] c, input logic [3:0] ra, input logic [3:0] ta,
                      input string tag);
    logic [3:0] p;
    logic [3:0] em, ackq;
    bit legal, txok;
    req_valid = rv; req_tgt = tg; req_lanes = m; req_code = c; rx_ack = ra; tx_ack = ta;
    cur_tag = tag;
    p = '0;
    if (!init_done) begin
      model_reset();
      if (rv) p[0] = 1'b1;
    end else if (m_busy) begin
      ackq = clk_stable ? (m_side ? ta : ra) : 4'b0;
      m_pend = m_pend & ~ackq;
      if (m_pend == 0) begin m_busy = 0; p[3] = 1'b1; end
      else if (m_cnt + 1 >= LIM) begin m_busy = 0; p[2] = 1'b1; end
      else m_cnt++;
      if (rv) p[0] = 1'b1;
    end else if (rv) begin
      legal = (tg < 5) && (c == 3'd0 || c == 3'd2);
      em = bonded ? ((m != 0) ? 4'b0001 : 4'b0000) : m;
      txok = 1;
      for (int i = 0; i < NL; i++) if (em[i] && m_txp[i] != 2'b00) txok = 0;
      if (!legal) p[1] = 1'b1;
      else if (em == 0 || (tg == 3'd1 && !txok)) p[0] = 1'b1;
      else begin
        for (int i = 0; i < NL; i++) if (em[i]) begin
          case (tg)
            3'd0: m_rxp[i] = c[1:0];
            3'd1: m_rxr[i] = c[1:0];
            3'd2: m_txp[i] = c[1:0];
            3'd3: m_txr[i] = c[1:0];
            default: m_txs[i] = c;
          endcase
        end
        m_busy = 1; m_pend = em; m_side = (tg >= 3'd2); m_cnt = 0;
      end
    end
    if (p != 0) q.push_back('{p, tag});
    @(negedge clk);
    req_valid = 1'b0; rx_ack = '0; tx_ack = '0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'h0, tag);
  endtask

  // monitor: compares state every cycle and pops expected status pulses
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        logic [3:0] pv;
        check({rx_pwr, rx_rate, tx_pwr, tx_rate, tx_srate} == model_flat(),
              {cur_tag, " fields"}, 64'({rx_pwr, rx_rate, tx_pwr, tx_rate, tx_srate}), 64'(model_flat()));
        check(busy == m_busy, {cur_tag, " busy"}, 64'(busy), 64'(m_busy));
        pv = {done, err_tmo, err_code, req_refused};
        if (pv != 0) begin
          if (q.size() == 0) check(0, {cur_tag, " unexpected pulse"}, 64'(pv), 64'(0));
          else begin
            item_t it;
            it = q.pop_front();
            check(pv == it.p, {it.tag, " pulses"}, 64'(pv), 64'(it.p));
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R2: reset values visible while reset is held
    check(rx_pwr == 8'hAA && tx_pwr == 8'hAA && rx_rate == 0 && tx_rate == 0 && tx_srate == 0,
          "R2 reset state", 64'({rx_pwr, tx_pwr}), 64'h0000AAAA);
    rst_n = 1'b1;
    idle(2, "R2");
    step(1, 3'd2, 4'hF, 3'd0, 4'h0, 4'h0, "R2");     // refused before init
    init_done = 1'b1; clk_stable = 1'b1;
    idle(1, "R2");
    step(1, 3'd1, 4'h1, 3'd2, 4'h0, 4'h0, "R8");     // rx rate before tx active
    step(1, 3'd2, 4'hF, 3'd0, 4'h0, 4'h0, "R1");     // tx power on
    step(0, 3'd0, 4'h0, 3'd0, 4'hF, 4'h0, "R6");     // wrong-side ack
    step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'h3, "R5");
    step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'hC, "R5");     // completes
    idle(1, "R5");
    step(1, 3'd1, 4'h2, 3'd1, 4'h0, 4'h0, "R3");     // reserved rate 01
    step(1, 3'd6, 4'hF, 3'd0, 4'h0, 4'h0, "R3");     // reserved target
    step(1, 3'd4, 4'hF, 3'd3, 4'h0, 4'h0, "R3");     // reserved sample rate
    step(1, 3'd0, 4'hF, 3'd1, 4'h0, 4'h0, "R1");     // reserved power code
    step(1, 3'd0, 4'h0, 3'd2, 4'h0, 4'h0, "R4");     // empty mask
    step(1, 3'd1, 4'h2, 3'd2, 4'h0, 4'h0, "R8");     // rx quarter rate lane 1
    step(1, 3'd3, 4'h1, 3'd2, 4'h0, 4'h0, "R9");     // refused while busy
    clk_stable = 1'b0;
    step(0, 3'd0, 4'h0, 3'd0, 4'h2, 4'h0, "R6");     // untrusted ack
    clk_stable = 1'b1;
    step(0, 3'd0, 4'h0, 3'd0, 4'h2, 4'h0, "R5");
    step(1, 3'd4, 4'h8, 3'd2, 4'h0, 4'h0, "R4");     // sample rate lane 3
    step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'h8, "R4");
    step(1, 3'd3, 4'h5, 3'd2, 4'h0, 4'h0, "R4");     // tx rate lanes 0 and 2
    step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'h5, "R4");
    step(1, 3'd0, 4'h4, 3'd0, 4'h0, 4'h0, "R10");    // never acknowledged
    idle(7, "R10");
    bonded = 1'b1;
    step(1, 3'd0, 4'hE, 3'd0, 4'h0, 4'h0, "R7");
    step(0, 3'd0, 4'h0, 3'd0, 4'hE, 4'h0, "R7");     // upper-lane acks do nothing
    step(0, 3'd0, 4'h0, 3'd0, 4'h1, 4'h0, "R7");
    step(1, 3'd2, 4'hF, 3'd2, 4'h0, 4'h0, "R7");
    step(0, 3'd0, 4'h0, 3'd0, 4'h0, 4'h1, "R7");
    bonded = 1'b0;
    idle(1, "R7");
    init_done = 1'b0;
    idle(2, "R2");
    step(1, 3'd0, 4'hF, 3'd0, 4'h0, 4'h0, "R2");
    idle(2, "R2");
    check(q.size() == 0, "R5 pending expectations", 64'(q.size()), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule